// File: doc/BRIEF.md
# Coincident Edge Sync Pulse Generator

This block runs on a fast source clock that feeds two divided bank clocks, bank A and bank C, each with its own integer divide ratio. It does not build those bank clocks. It follows their phase with counters and drives an active-low sync output. The output warns that both banks are about to rise on the same source edge.

The output drops one period of the faster bank clock before each shared rising edge. It returns high on the source cycle in which that shared edge occurs. This also holds when neither ratio divides the other, such as 4 against 6 or 6 against 8, so that the two bank frequencies are in a non-integer relation.

The two divide ratios are captured while reset is held. The counters restart from an aligned phase when reset is released, so source cycle zero counts as a shared edge. The output comes straight from a flop, so it only moves on source clock edges.

Top module: `coincident_sync`

## Requirements
- R1: In the first source cycle after reset is released (t = 0, counting source rising edges since release), `sync_n` is 1.
- R2: With unequal effective ratios a and c, let L = lcm(a, c) and P = min(a, c). Then `sync_n` is 0 exactly when (t mod L) >= L - P. This is the last P source cycles before each shared edge.
- R3: With unequal ratios, `sync_n` is 1 in every cycle where t mod L = 0, which is the cycle of a shared rising edge.
- R4: The rule of R2 also holds when neither ratio divides the other (for example 4 and 6, or 6 and 8).
- R5: With equal effective ratios d, every bank edge is shared. `sync_n` is then 0 exactly when (t mod d) >= d/2, rounded down, and otherwise 1.
- R6: `div_a` and `div_c` are sampled only on source edges while `rst` is 1. Changes to them while `rst` is 0 have no effect on `sync_n`.
- R7: A divide input value below 2 (0 or 1) is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common fast source clock |
| rst | input | 1 | Synchronous active-high reset; also captures the divide ratios |
| div_a | input | 5 | Bank A divide ratio in source cycles |
| div_c | input | 5 | Bank C divide ratio in source cycles |
| sync_n | output | 1 | Active-low warning of the next shared rising edge |

## Verification
The assertions check the following properties on every cycle:
- Every low stretch of `sync_n` lasts no longer than the faster bank period.
- Every rise lands on a cycle where both bank phase counters are at zero.
- With unequal ratios, every fall coincides with both look-ahead counters at zero.
- The captured ratios are never below two and stay frozen outside reset.

Only the bench's scenarios can show the exact position and width of each low window, and its repetition over the full lcm period, for each ratio pair. The same holds for the half-period shape in the equal-ratio case and for the effect of changing the divide inputs after reset. The bench compares every cycle against an lcm-based model for directed pairs and randomly drawn pairs.

// File: rtl/csync_pkg.sv
package csync_pkg;

    localparam int DIV_W = 5;
    localparam int LANES = 4;

    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        div_t a;
        div_t c;
    } ratio_s;

    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_EQUAL = 1'b1
    } mode_e;

    typedef enum int {
        LANE_NOW_A   = 0,
        LANE_NOW_C   = 1,
        LANE_AHEAD_A = 2,
        LANE_AHEAD_C = 3
    } lane_e;

    function automatic div_t clamp_div(div_t d, div_t lo);
        return (d < lo) ? lo : d;
    endfunction

    function automatic div_t min_div(div_t x, div_t y);
        return (x < y) ? x : y;
    endfunction

    // Phase of a counter of period own, shifted forward by span (span <= own).
    function automatic div_t lead_start(div_t own, div_t span);
        return (span == own) ? '0 : span;
    endfunction

endpackage

// File: rtl/csync_ratio_capture.sv
module csync_ratio_capture
    import csync_pkg::*;
#(
    parameter int MIN_DIV = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  div_t   div_a_in,
    input  div_t   div_c_in,
    output ratio_s live,
    output ratio_s held
);
    localparam div_t FLOOR = div_t'(MIN_DIV);

    always_comb begin
        live.a = clamp_div(div_a_in, FLOOR);
        live.c = clamp_div(div_c_in, FLOOR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= live;
        end
    end
endmodule

// File: rtl/csync_phase_counter.sv
module csync_phase_counter
    import csync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  div_t period,
    input  div_t start,
    output div_t cnt_q,
    output div_t cnt_nx,
    output logic wrap_nx
);
    div_t last;

    always_comb begin
        last    = div_t'(period - div_t'(1));
        wrap_nx = (cnt_q == last);
        cnt_nx  = wrap_nx ? '0 : div_t'(cnt_q + div_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= start;
        end else begin
            cnt_q <= cnt_nx;
        end
    end
endmodule

// File: rtl/csync_output_state.sv
module csync_output_state
    import csync_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  warn_nx,
    input  logic  coin_nx,
    input  logic  late_half_nx,
    output logic  sync_n
);
    logic sync_d;

    always_comb begin
        sync_d = sync_n;
        unique case (mode)
            MODE_EQUAL: sync_d = ~late_half_nx;
            MODE_SPLIT: begin
                if (warn_nx) begin
                    sync_d = 1'b0;
                end else if (coin_nx) begin
                    sync_d = 1'b1;
                end
            end
            default: sync_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_n <= 1'b1;
        end else begin
            sync_n <= sync_d;
        end
    end
endmodule

// File: rtl/coincident_sync.sv
module coincident_sync
    import csync_pkg::*;
#(
    parameter int MIN_DIV = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_a,
    input  logic [DIV_W-1:0] div_c,
    output logic             sync_n
);
    ratio_s cfg_live;
    ratio_s cfg_q;
    div_t   span_live;
    mode_e  mode;

    div_t lane_period [LANES];
    div_t lane_start  [LANES];
    div_t lane_cnt    [LANES];
    div_t lane_nx     [LANES];
    logic lane_wrap   [LANES];

    logic warn_nx;
    logic coin_nx;
    logic late_half_nx;

    csync_ratio_capture #(.MIN_DIV(MIN_DIV)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .div_a_in (div_a),
        .div_c_in (div_c),
        .live     (cfg_live),
        .held     (cfg_q)
    );

    always_comb begin
        span_live = min_div(cfg_live.a, cfg_live.c);

        lane_period[LANE_NOW_A]   = cfg_q.a;
        lane_period[LANE_NOW_C]   = cfg_q.c;
        lane_period[LANE_AHEAD_A] = cfg_q.a;
        lane_period[LANE_AHEAD_C] = cfg_q.c;

        lane_start[LANE_NOW_A]    = '0;
        lane_start[LANE_NOW_C]    = '0;
        lane_start[LANE_AHEAD_A]  = lead_start(cfg_live.a, span_live);
        lane_start[LANE_AHEAD_C]  = lead_start(cfg_live.c, span_live);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        csync_phase_counter u_cnt (
            .clk     (clk),
            .rst     (rst),
            .period  (lane_period[g]),
            .start   (lane_start[g]),
            .cnt_q   (lane_cnt[g]),
            .cnt_nx  (lane_nx[g]),
            .wrap_nx (lane_wrap[g])
        );
    end

    always_comb begin
        mode         = (cfg_q.a == cfg_q.c) ? MODE_EQUAL : MODE_SPLIT;
        coin_nx      = lane_wrap[LANE_NOW_A] & lane_wrap[LANE_NOW_C];
        warn_nx      = lane_wrap[LANE_AHEAD_A] & lane_wrap[LANE_AHEAD_C];
        late_half_nx = (lane_nx[LANE_NOW_A] >= (cfg_q.a >> 1));
    end

    csync_output_state u_out (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .warn_nx      (warn_nx),
        .coin_nx      (coin_nx),
        .late_half_nx (late_half_nx),
        .sync_n       (sync_n)
    );
endmodule

// File: rtl/coincident_sync_checker.sv
module coincident_sync_checker
    import csync_pkg::*;
#(
    parameter int MIN_DIV = 2
) (
    input logic   clk,
    input logic   rst,
    input logic   sync_n,
    input ratio_s cfg,
    input div_t   now_a,
    input div_t   now_c,
    input div_t   ahead_a,
    input div_t   ahead_c
);
    logic           rst_d;
    logic [DIV_W:0] low_run;
    div_t           span;

    assign span = min_div(cfg.a, cfg.c);

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            low_run <= '0;
        end else begin
            low_run <= sync_n ? '0 : (DIV_W+1)'(low_run + 1'b1);
        end
    end

    // R1: the cycle after a reset edge shows sync_n high
    always @(posedge clk) begin
        if (rst_d === 1'b1) begin
            p_reset_high_r1: assert (sync_n === 1'b1)
                else $error("p_reset_high_r1");
        end
    end

    // R2: no low stretch lasts longer than the faster bank period
    p_window_len_r2: assert property (@(posedge clk) disable iff (rst)
        low_run <= {1'b0, span});

    // R2: an unequal-ratio fall lines up with both look-ahead phases at zero
    p_fall_ahead_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(sync_n) && (cfg.a != cfg.c)) |-> (ahead_a == '0 && ahead_c == '0));

    // R3: every rise lands on a shared rising edge
    p_rise_coincide_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n) |-> (now_a == '0 && now_c == '0));

    // R6: captured ratios hold outside reset
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg));

    // R7: captured ratios never fall under the floor
    p_floor_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg.a >= div_t'(MIN_DIV)) && (cfg.c >= div_t'(MIN_DIV)));
endmodule

bind coincident_sync coincident_sync_checker #(.MIN_DIV(MIN_DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sync_n  (sync_n),
    .cfg     (cfg_q),
    .now_a   (lane_cnt[0]),
    .now_c   (lane_cnt[1]),
    .ahead_a (lane_cnt[2]),
    .ahead_c (lane_cnt[3])
);

// File: tb/coincident_sync_test.sv
`timescale 1ns/1ps
module coincident_sync_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] div_a = 5'd4;
    logic [4:0] div_c = 5'd2;
    logic       sync_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    coincident_sync uut (
        .clk    (clk),
        .rst    (rst),
        .div_a  (div_a),
        .div_c  (div_c),
        .sync_n (sync_n)
    );

    function automatic int eff(int d);
        return (d < 2) ? 2 : d;
    endfunction

    function automatic int gcd(int x, int y);
        while (y != 0) begin
            int r = x % y;
            x = y;
            y = r;
        end
        return x;
    endfunction

    function automatic int lcm(int x, int y);
        return (x / gcd(x, y)) * y;
    endfunction

    function automatic bit expect_sync(int a, int c, int t);
        int l, p;
        if (a == c) return !((t % a) >= (a / 2));
        l = lcm(a, c);
        p = (a < c) ? a : c;
        return !((t % l) >= (l - p));
    endfunction

    function automatic string pick_tag(int a, int c, int t, string force_tag);
        if (force_tag != "") return force_tag;
        if (t == 0) return "R1";
        if (a == c) return "R5";
        if ((t % lcm(a, c)) == 0) return "R3";
        if ((a % c != 0) && (c % a != 0)) return "R4";
        return "R2";
    endfunction

    task automatic check(string tag, bit got, bit exp, int t, int a, int c);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: sync_n=%0b expected %0b (t=%0d a=%0d c=%0d)",
                     tag, got, exp, t, a, c);
        end
    endtask

    task automatic run_case(int ra, int rc, int laps, string force_tag, bit scramble);
        int a, c, n;
        a = eff(ra);
        c = eff(rc);
        n = laps * lcm(a, c) + 3;
        @(negedge clk);
        rst   = 1'b1;
        div_a = 5'(ra);
        div_c = 5'(rc);
        @(negedge clk);
        rst = 1'b0;
        check((force_tag != "") ? force_tag : "R1", sync_n, 1'b1, 0, a, c);
        for (int t = 1; t <= n; t++) begin
            if (scramble) begin
                div_a = 5'($urandom_range(0, 31));
                div_c = 5'($urandom_range(0, 31));
            end
            @(negedge clk);
            check(pick_tag(a, c, t, force_tag), sync_n, expect_sync(a, c, t), t, a, c);
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check("R1", sync_n, 1'b1, -1, 4, 2);   // held in reset

        run_case(4, 2, 3, "", 0);      // R2 integer ratio 2:1 style
        run_case(8, 2, 3, "", 0);      // R2 4:1
        run_case(4, 8, 3, "", 0);      // R2 slower C
        run_case(12, 2, 3, "", 0);     // R2 6:1
        run_case(6, 2, 3, "", 0);      // R2 3:1
        run_case(6, 8, 3, "", 0);      // R4 4:3
        run_case(4, 6, 3, "", 0);      // R4 3:2
        run_case(8, 12, 3, "", 0);     // R4
        run_case(4, 4, 4, "", 0);      // R5 equal
        run_case(2, 2, 4, "", 0);      // R5 equal fastest
        run_case(7, 7, 4, "", 0);      // R5 odd equal
        run_case(6, 4, 3, "R6", 1);    // R6 inputs scrambled after reset
        run_case(0, 3, 3, "R7", 0);    // R7 zero treated as 2
        run_case(1, 5, 3, "R7", 0);    // R7 one treated as 2
        run_case(1, 0, 3, "R7", 0);    // R7 both floored -> equal
        for (int k = 0; k < 10; k++) begin
            run_case($urandom_range(2, 16), $urandom_range(2, 16), 2, "", 0);
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule